// File: doc/BRIEF.md
# Paused Dual-Port Coefficient and Configuration Loader

This block takes two narrow word streams, port A and port B, and turns each into writes to coefficient memory or to a shared set of configuration registers. Each port has a word bus, an active-low load strobe and a pause input. A transfer begins when the strobe falls. The first accepted word is an address. The words that follow are data for the target that the address picks.

An address below 0x100 picks one coefficient row. The data words that follow then fill that row in each multiplier bank of the port, one bank per word, starting from bank 0 and going up. An address from 0x200 up picks one configuration register. Each following data word writes the next register in turn, until the last register has been written. Pause freezes a port in place, so a slow host can feed words at any rate. Raising the strobe mid-transfer drops the transfer at once.

The configuration registers are shared by both ports. When both ports write the same register in the same cycle, port B's value is kept. Port A still moves on to its next register as if its write had landed.

Top module: `coef_cfg_loader`

## Requirements
- R1: During reset and in the first cycle after it, no memory write enable and no register write strobe is asserted. All configuration registers read zero.
- R2: A transfer starts only on a HIGH-to-LOW transition of the port's load strobe that follows a cycle in which the strobe was sampled HIGH after reset. A strobe held LOW straight out of reset produces no writes.
- R3: After an address word below 0x100, the next NUM_BANKS accepted data words (default 4) write that row in bank 0, 1, 2, 3 in that order. The write appears on the port's memory outputs in the cycle after the word is sampled: a one-hot bank enable with bit k for bank k, the row, and the word. Words after the last bank write nothing.
- R4: While a port's pause input is HIGH, that port performs no write and keeps its position, including while the address word is awaited. The next word accepted after pause goes LOW is taken at the same position.
- R5: A load strobe sampled HIGH during a transfer writes nothing for that cycle and ends the transfer. A later falling edge starts a new transfer whose first word is an address.
- R6: An address word 0x200+k (k < NUM_CFG, default 6) makes the next accepted data words write registers k, k+1, and so on up to NUM_CFG-1. Each write sets bit j of `cfg_wr` for one cycle, and register j becomes visible on `cfg_q[12*j +: 12]` in that same cycle. Words after the last register write nothing.
- R7: Reserved register bits, bits 11:8 under the default keep mask 0x0FF, are stored as zero whatever the word carries.
- R8: If both ports write the same register in the same cycle, the register takes port B's word. Port A still advances to its next register.
- R9: An address from 0x100 to 0x1FF, or from 0x200+NUM_CFG upward, causes no memory or register write for the rest of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_ld_n | input | 1 | Port A load strobe, active low |
| a_pause | input | 1 | Port A hold |
| a_word | input | 12 | Port A address or data word |
| b_ld_n | input | 1 | Port B load strobe, active low |
| b_pause | input | 1 | Port B hold |
| b_word | input | 12 | Port B address or data word |
| a_mem_we | output | NUM_BANKS | Port A one-hot bank write enable |
| a_mem_row | output | 8 | Port A coefficient row |
| a_mem_data | output | 12 | Port A coefficient data |
| b_mem_we | output | NUM_BANKS | Port B one-hot bank write enable |
| b_mem_row | output | 8 | Port B coefficient row |
| b_mem_data | output | 12 | Port B coefficient data |
| cfg_wr | output | NUM_CFG | Per-register write strobe |
| cfg_q | output | 12*NUM_CFG | Configuration register contents |

## Verification
The case that is hardest to reach from the ports is a collision: both ports must hit one register on the same edge. The bench lines up both strobe falls on one cycle and gives both ports the same register address. It checks that B's word is kept, then stops port B and sends one more word on port A to show that A has moved to the next register. Pause is driven during the address slot and between data words, and aborts and restarts are mixed into the transfers. All 256 rows are swept on both ports at the same time, using data values computed from the row and bank.

// File: rtl/loader_pkg.sv
// Shared types for the coefficient/configuration loader.
// Assumes nothing beyond standard SystemVerilog enums.
package loader_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,   // waiting for a strobe fall
        SQ_ADDR,   // started, address word not yet accepted (paused)
        SQ_COEF,   // streaming coefficient words across banks
        SQ_CFG,    // streaming configuration register words
        SQ_DONE    // target exhausted or invalid, ignore words
    } seq_state_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_COEF,
        TGT_CFG
    } tgt_t;
endpackage

// File: rtl/loader_decode.sv
// Address word decoder: classifies an address word as a coefficient row,
// a configuration register index, or nothing.
// Assumes the row space (2**ROW_W) lies below CFG_BASE.
module loader_decode
    import loader_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int ROW_W    = 8,
    parameter int NUM_CFG  = 6,
    parameter int CFG_BASE = 'h200,
    localparam int CFG_IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic [WORD_W-1:0]    word,
    output tgt_t                 tgt,
    output logic [ROW_W-1:0]     row,
    output logic [CFG_IDX_W-1:0] cfg_idx
);
    localparam logic [WORD_W-1:0] ROW_LIM = WORD_W'(1 << ROW_W);
    localparam logic [WORD_W-1:0] CFG_LO  = WORD_W'(CFG_BASE);
    localparam logic [WORD_W-1:0] CFG_HI  = WORD_W'(CFG_BASE + NUM_CFG);

    logic [WORD_W-1:0] offset;

    // Classify the word by address range.
    always_comb begin
        offset  = word - CFG_LO;
        row     = word[ROW_W-1:0];
        cfg_idx = CFG_IDX_W'(offset);
        if (word < ROW_LIM)
            tgt = TGT_COEF;
        else if (word >= CFG_LO && word < CFG_HI)
            tgt = TGT_CFG;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/loader_seq.sv
// One loader port: detects the strobe fall, takes the address word, then
// steps through banks or registers one accepted word at a time.
// Coefficient writes leave registered; config requests are combinational
// so the shared register file can arbitrate them on the same edge.
// Assumes the strobe is seen HIGH at least once after reset before use.
module loader_seq
    import loader_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int NUM_CFG   = 6,
    parameter int CFG_BASE  = 'h200,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CFG_IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_n,
    input  logic                 pause,
    input  logic [WORD_W-1:0]    word,
    output logic [NUM_BANKS-1:0] mem_we,
    output logic [ROW_W-1:0]     mem_row,
    output logic [WORD_W-1:0]    mem_data,
    output logic                 cfg_req,
    output logic [CFG_IDX_W-1:0] cfg_idx,
    output logic [WORD_W-1:0]    cfg_data
);
    seq_state_t st_q, st_d;
    logic                 ld_hi_q;
    logic [BANK_W-1:0]    bank_q, bank_d;
    logic [ROW_W-1:0]     row_q, row_d;
    logic [CFG_IDX_W-1:0] cidx_q, cidx_d;
    logic                 take_addr;
    logic                 coef_wr;
    logic [NUM_BANKS-1:0] bank_hit;

    tgt_t                 dec_tgt;
    logic [ROW_W-1:0]     dec_row;
    logic [CFG_IDX_W-1:0] dec_idx;

    loader_decode #(
        .WORD_W(WORD_W), .ROW_W(ROW_W), .NUM_CFG(NUM_CFG), .CFG_BASE(CFG_BASE)
    ) u_dec (
        .word(word), .tgt(dec_tgt), .row(dec_row), .cfg_idx(dec_idx)
    );

    // One-hot bank select from the current bank counter.
    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
            assign bank_hit[g] = (bank_q == BANK_W'(g));
        end
    endgenerate

    // Next-state and write-request logic for one accepted word per cycle.
    always_comb begin
        st_d      = st_q;
        bank_d    = bank_q;
        row_d     = row_q;
        cidx_d    = cidx_q;
        take_addr = 1'b0;
        coef_wr   = 1'b0;
        cfg_req   = 1'b0;
        if (ld_n) begin
            st_d = SQ_IDLE;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (ld_hi_q) begin
                        if (pause) st_d = SQ_ADDR;
                        else       take_addr = 1'b1;
                    end
                end
                SQ_ADDR: begin
                    if (!pause) take_addr = 1'b1;
                end
                SQ_COEF: begin
                    if (!pause) begin
                        coef_wr = 1'b1;
                        if (bank_q == BANK_W'(NUM_BANKS - 1)) st_d = SQ_DONE;
                        else bank_d = bank_q + 1'b1;
                    end
                end
                SQ_CFG: begin
                    if (!pause) begin
                        cfg_req = 1'b1;
                        if (cidx_q == CFG_IDX_W'(NUM_CFG - 1)) st_d = SQ_DONE;
                        else cidx_d = cidx_q + 1'b1;
                    end
                end
                default: st_d = SQ_DONE;
            endcase
            if (take_addr) begin
                unique case (dec_tgt)
                    TGT_COEF: begin
                        st_d   = SQ_COEF;
                        bank_d = '0;
                        row_d  = dec_row;
                    end
                    TGT_CFG: begin
                        st_d   = SQ_CFG;
                        cidx_d = dec_idx;
                    end
                    default: st_d = SQ_DONE;
                endcase
            end
        end
    end

    assign cfg_idx  = cidx_q;
    assign cfg_data = word;

    // Sequencer state and strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            ld_hi_q <= 1'b0;
            bank_q  <= '0;
            row_q   <= '0;
            cidx_q  <= '0;
        end else begin
            st_q    <= st_d;
            ld_hi_q <= ld_n;
            bank_q  <= bank_d;
            row_q   <= row_d;
            cidx_q  <= cidx_d;
        end
    end

    // Registered coefficient memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we   <= '0;
            mem_row  <= '0;
            mem_data <= '0;
        end else begin
            mem_we   <= coef_wr ? bank_hit : '0;
            mem_row  <= row_q;
            mem_data <= word;
        end
    end
endmodule

// File: rtl/cfg_regfile.sv
// Shared configuration registers written by two loader ports.
// Port B wins when both address the same register in one cycle.
// Reserved bits (clear in KEEP_MASK) are stored as zero.
module cfg_regfile #(
    parameter int WORD_W  = 12,
    parameter int NUM_CFG = 6,
    parameter logic [WORD_W-1:0] KEEP_MASK = 12'h0FF,
    localparam int CFG_IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      a_req,
    input  logic [CFG_IDX_W-1:0]      a_idx,
    input  logic [WORD_W-1:0]         a_data,
    input  logic                      b_req,
    input  logic [CFG_IDX_W-1:0]      b_idx,
    input  logic [WORD_W-1:0]         b_data,
    output logic [NUM_CFG-1:0]        cfg_wr,
    output logic [NUM_CFG*WORD_W-1:0] cfg_q
);
    generate
        for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
            logic sel_a, sel_b;
            assign sel_a = a_req && (a_idx == CFG_IDX_W'(i));
            assign sel_b = b_req && (b_idx == CFG_IDX_W'(i));

            // Register i with fixed B-over-A priority and reserved-bit clearing.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[i*WORD_W +: WORD_W] <= '0;
                    cfg_wr[i]                 <= 1'b0;
                end else begin
                    cfg_wr[i] <= sel_a | sel_b;
                    if (sel_b)
                        cfg_q[i*WORD_W +: WORD_W] <= b_data & KEEP_MASK;
                    else if (sel_a)
                        cfg_q[i*WORD_W +: WORD_W] <= a_data & KEEP_MASK;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/coef_cfg_loader.sv
// Top: two loader ports (A, B), each with its own coefficient memory write
// port, sharing one configuration register file.
// Assumes each strobe is held HIGH after reset before the first transfer.
module coef_cfg_loader #(
    parameter int WORD_W    = 12,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int NUM_CFG   = 6,
    parameter int CFG_BASE  = 'h200,
    parameter logic [WORD_W-1:0] CFG_KEEP_MASK = 12'h0FF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      a_ld_n,
    input  logic                      a_pause,
    input  logic [WORD_W-1:0]         a_word,
    input  logic                      b_ld_n,
    input  logic                      b_pause,
    input  logic [WORD_W-1:0]         b_word,
    output logic [NUM_BANKS-1:0]      a_mem_we,
    output logic [ROW_W-1:0]          a_mem_row,
    output logic [WORD_W-1:0]         a_mem_data,
    output logic [NUM_BANKS-1:0]      b_mem_we,
    output logic [ROW_W-1:0]          b_mem_row,
    output logic [WORD_W-1:0]         b_mem_data,
    output logic [NUM_CFG-1:0]        cfg_wr,
    output logic [NUM_CFG*WORD_W-1:0] cfg_q
);
    localparam int CFG_IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

    logic                 a_req, b_req;
    logic [CFG_IDX_W-1:0] a_idx, b_idx;
    logic [WORD_W-1:0]    a_cdata, b_cdata;

    loader_seq #(
        .WORD_W(WORD_W), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
        .NUM_CFG(NUM_CFG), .CFG_BASE(CFG_BASE)
    ) u_seq_a (
        .clk(clk), .rst_n(rst_n), .ld_n(a_ld_n), .pause(a_pause), .word(a_word),
        .mem_we(a_mem_we), .mem_row(a_mem_row), .mem_data(a_mem_data),
        .cfg_req(a_req), .cfg_idx(a_idx), .cfg_data(a_cdata)
    );

    loader_seq #(
        .WORD_W(WORD_W), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
        .NUM_CFG(NUM_CFG), .CFG_BASE(CFG_BASE)
    ) u_seq_b (
        .clk(clk), .rst_n(rst_n), .ld_n(b_ld_n), .pause(b_pause), .word(b_word),
        .mem_we(b_mem_we), .mem_row(b_mem_row), .mem_data(b_mem_data),
        .cfg_req(b_req), .cfg_idx(b_idx), .cfg_data(b_cdata)
    );

    cfg_regfile #(
        .WORD_W(WORD_W), .NUM_CFG(NUM_CFG), .KEEP_MASK(CFG_KEEP_MASK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_idx(a_idx), .a_data(a_cdata),
        .b_req(b_req), .b_idx(b_idx), .b_data(b_cdata),
        .cfg_wr(cfg_wr), .cfg_q(cfg_q)
    );
endmodule

// File: rtl/coef_cfg_loader_chk.sv
// Port-level properties of the loader, bound to every coef_cfg_loader.
module coef_cfg_loader_chk #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_CFG   = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 a_ld_n,
    input logic                 a_pause,
    input logic                 b_ld_n,
    input logic                 b_pause,
    input logic [NUM_BANKS-1:0] a_mem_we,
    input logic [NUM_BANKS-1:0] b_mem_we,
    input logic [NUM_CFG-1:0]   cfg_wr
);
    // R1: reset leaves no write pending in the following cycle.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (a_mem_we == '0 && b_mem_we == '0 && cfg_wr == '0));

    // R3: at most one bank written per port per cycle.
    a_r3_onehot_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_mem_we) && $onehot0(b_mem_we));

    // R4: a paused port writes nothing.
    a_r4_pause_blocks_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_pause |=> a_mem_we == '0);
    a_r4_pause_blocks_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_pause |=> b_mem_we == '0);

    // R5: a HIGH strobe writes nothing.
    a_r5_strobe_high_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_ld_n |=> a_mem_we == '0);
    a_r5_strobe_high_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_ld_n |=> b_mem_we == '0);

    // R6 / R8: at most two registers per cycle, one per active port.
    a_r6_cfg_wr_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cfg_wr) <= 2);
    a_r6_cfg_needs_port: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr != '0) |-> ($past(!a_ld_n && !a_pause) || $past(!b_ld_n && !b_pause)));
endmodule

bind coef_cfg_loader coef_cfg_loader_chk #(
    .NUM_BANKS(NUM_BANKS), .NUM_CFG(NUM_CFG)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_ld_n(a_ld_n), .a_pause(a_pause), .b_ld_n(b_ld_n), .b_pause(b_pause),
    .a_mem_we(a_mem_we), .b_mem_we(b_mem_we), .cfg_wr(cfg_wr)
);

// File: tb/sim_coef_cfg_loader.sv
module sim_coef_cfg_loader;
    localparam int NB = 4;
    localparam int NC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_ld_n = 1'b0, a_pause = 1'b0, b_ld_n = 1'b0, b_pause = 1'b0;
    logic [11:0] a_word = '0, b_word = '0;
    logic [NB-1:0] a_mem_we, b_mem_we;
    logic [7:0] a_mem_row, b_mem_row;
    logic [11:0] a_mem_data, b_mem_data;
    logic [NC-1:0] cfg_wr;
    logic [NC*12-1:0] cfg_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    coef_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n),
        .a_ld_n(a_ld_n), .a_pause(a_pause), .a_word(a_word),
        .b_ld_n(b_ld_n), .b_pause(b_pause), .b_word(b_word),
        .a_mem_we(a_mem_we), .a_mem_row(a_mem_row), .a_mem_data(a_mem_data),
        .b_mem_we(b_mem_we), .b_mem_row(b_mem_row), .b_mem_data(b_mem_data),
        .cfg_wr(cfg_wr), .cfg_q(cfg_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive both ports at the falling edge, then sample just after the rising edge.
    task automatic step(input logic al, input logic ap, input int aw,
                        input logic bl, input logic bp, input int bw);
        @(negedge clk);
        a_ld_n = al; a_pause = ap; a_word = 12'(aw);
        b_ld_n = bl; b_pause = bp; b_word = 12'(bw);
        @(posedge clk);
        #1;
    endtask

    task automatic chk_a(input int bank, input int row, input int data, input string req);
        check(a_mem_we == NB'(1 << bank), req, int'(a_mem_we), 1 << bank);
        check(a_mem_row == 8'(row), req, int'(a_mem_row), row);
        check(a_mem_data == 12'(data), req, int'(a_mem_data), data);
    endtask

    task automatic chk_b(input int bank, input int row, input int data, input string req);
        check(b_mem_we == NB'(1 << bank), req, int'(b_mem_we), 1 << bank);
        check(b_mem_row == 8'(row), req, int'(b_mem_row), row);
        check(b_mem_data == 12'(data), req, int'(b_mem_data), data);
    endtask

    function automatic int reg_of(input int k);
        return int'(cfg_q[k*12 +: 12]);
    endfunction

    function automatic int pat(input int row, input int bank, input int port);
        return (row * 37 + bank * 5 + port * 1001 + 3) & 12'hFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(a_mem_we == '0 && b_mem_we == '0, "R1 no mem write", int'(a_mem_we), 0);
        check(cfg_wr == '0, "R1 no cfg strobe", int'(cfg_wr), 0);
        for (int k = 0; k < NC; k++) check(reg_of(k) == 0, "R1 cfg zero", reg_of(k), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(a_mem_we == '0 && cfg_wr == '0, "R1 first cycle quiet", int'(a_mem_we), 0);

        // R2: strobe held low out of reset does nothing
        step(0, 0, 'h005, 0, 0, 'h205);
        check(a_mem_we == '0 && b_mem_we == '0, "R2 no start", int'(a_mem_we), 0);
        step(0, 0, 'h111, 0, 0, 'h0AA);
        check(a_mem_we == '0 && b_mem_we == '0 && cfg_wr == '0, "R2 no start", int'(a_mem_we), 0);
        step(0, 0, 'h222, 0, 0, 'h0BB);
        check(a_mem_we == '0 && b_mem_we == '0 && cfg_wr == '0, "R2 no start", int'(cfg_wr), 0);

        // R3: full row sweep on both ports at once
        for (int r = 0; r < 256; r++) begin
            step(1, 0, 0, 1, 0, 0);
            step(0, 0, r, 0, 0, 255 - r);
            for (int b = 0; b < NB; b++) begin
                step(0, 0, pat(r, b, 0), 0, 0, pat(255 - r, b, 1));
                chk_a(b, r, pat(r, b, 0), "R3 sweep A");
                chk_b(b, 255 - r, pat(255 - r, b, 1), "R3 sweep B");
            end
            step(0, 0, 'hABC, 0, 0, 'hDEF);
            check(a_mem_we == '0 && b_mem_we == '0, "R3 extra word ignored", int'(a_mem_we), 0);
            check(cfg_wr == '0, "R3 no cfg during coef", int'(cfg_wr), 0);
        end

        // R4: pause during address slot and between data words
        step(1, 0, 0, 1, 0, 0);
        step(0, 1, 'h010, 1, 0, 0);
        check(a_mem_we == '0, "R4 paused addr", int'(a_mem_we), 0);
        step(0, 0, 'h010, 1, 0, 0);
        check(a_mem_we == '0, "R4 addr word no write", int'(a_mem_we), 0);
        step(0, 0, 'h100, 1, 0, 0);
        chk_a(0, 'h10, 'h100, "R4 bank0");
        step(0, 1, 'h999, 1, 0, 0);
        check(a_mem_we == '0, "R4 paused data", int'(a_mem_we), 0);
        step(0, 1, 'h888, 1, 0, 0);
        check(a_mem_we == '0, "R4 paused data", int'(a_mem_we), 0);
        step(0, 0, 'h101, 1, 0, 0);
        chk_a(1, 'h10, 'h101, "R4 resume same position");

        // R5: abort mid-row, then restart straight into a new address
        step(1, 0, 'h777, 1, 0, 0);
        check(a_mem_we == '0, "R5 abort no write", int'(a_mem_we), 0);
        step(0, 0, 'h030, 1, 0, 0);
        check(a_mem_we == '0, "R5 restart addr", int'(a_mem_we), 0);
        step(0, 0, 'h300, 1, 0, 0);
        chk_a(0, 'h30, 'h300, "R5 restart at bank0");

        // R6 and R7: register stream from 0x202 to the end
        step(1, 0, 0, 1, 0, 0);
        step(0, 0, 'h202, 1, 0, 0);
        for (int k = 2; k < NC; k++) begin
            int v;
            v = (k * 'h321 + 'h9A5) & 'hFFF;
            step(0, 0, v, 1, 0, 0);
            check(cfg_wr == NC'(1 << k), "R6 strobe", int'(cfg_wr), 1 << k);
            check(reg_of(k) == (v & 'h0FF), "R7 masked value", reg_of(k), v & 'h0FF);
        end
        step(0, 0, 'hFFF, 1, 0, 0);
        check(cfg_wr == '0, "R6 extra word ignored", int'(cfg_wr), 0);
        check(reg_of(NC - 1) == (((NC - 1) * 'h321 + 'h9A5) & 'h0FF), "R6 last reg kept",
              reg_of(NC - 1), ((NC - 1) * 'h321 + 'h9A5) & 'h0FF);

        // R8: collision on register 0, then A continues alone
        step(1, 0, 0, 1, 0, 0);
        step(0, 0, 'h200, 0, 0, 'h200);
        step(0, 0, 'h011, 0, 0, 'h022);
        check(reg_of(0) == 'h022, "R8 B wins reg0", reg_of(0), 'h022);
        check(cfg_wr == 6'b000001, "R8 single strobe", int'(cfg_wr), 1);
        step(0, 0, 'h033, 0, 0, 'h044);
        check(reg_of(1) == 'h044, "R8 B wins reg1", reg_of(1), 'h044);
        step(0, 0, 'h055, 1, 0, 0);
        check(reg_of(2) == 'h055, "R8 A advanced to reg2", reg_of(2), 'h055);
        check(cfg_wr == 6'b000100, "R8 A strobe reg2", int'(cfg_wr), 4);

        // R9: invalid addresses write nothing
        step(1, 0, 0, 1, 0, 0);
        step(0, 0, 'h150, 0, 0, 'h200 + NC);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 'h0F0 + i, 0, 0, 'h0E0 + i);
            check(a_mem_we == '0 && b_mem_we == '0, "R9 no mem write", int'(a_mem_we), 0);
            check(cfg_wr == '0, "R9 no cfg write", int'(cfg_wr), 0);
        end
        check(reg_of(0) == 'h022, "R9 reg0 unchanged", reg_of(0), 'h022);

        step(1, 0, 0, 1, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule